// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Engine

This block is the timing engine of a bus master for a single-wire, open-drain, wired-AND bus. It produces the four standard-speed signal types: a reset with presence detection, a write-one slot, a write-zero slot and a read slot. A host picks the operation with a 2-bit code and a one-clock start strobe. A 1 µs tick enable paces every phase. The engine drives a pull-down enable and watches the resolved line level. It reports completion with a one-clock done strobe. A reset also returns a presence flag, and a read returns the sampled bit.

All timing counts 1 µs ticks from the clock edge that accepts the start strobe. Every slot lasts a fixed number of ticks. The line is pulled low only at the start of an operation, then released for the rest of it, so recovery and reset-high time are built into each operation. A start request is taken only while the engine is idle. Sequencing bytes, searching and any speed other than standard are left to the host.

Top module: `owm_slot_engine`

## Requirements
- R1: After reset deassertion, `driveLow`, `busy`, `doneStb`, `presenceFlag` and `readBit` are all 0.
- R2: `opCode` values are 2'b00 = reset, 2'b01 = write-one, 2'b10 = write-zero, 2'b11 = read. A `startReq` seen while idle makes `busy` and `driveLow` 1 from the next clock edge.
- R3: A reset holds `driveLow` for 500 tick edges, then releases the line, and keeps `busy` for 1000 tick edges in total.
- R4: `presenceFlag` takes the inverse of `lineIn` at the 570th tick edge of a reset, that is 70 µs after release. It holds that value until the next reset captures a new one.
- R5: A write-one holds `driveLow` for 6 tick edges and keeps `busy` for 70 tick edges.
- R6: A write-zero holds `driveLow` for 64 tick edges and keeps `busy` for 70 tick edges.
- R7: A read holds `driveLow` for 6 tick edges and keeps `busy` for 70 tick edges. `readBit` takes `lineIn` at the 13th tick edge and holds it until the next read.
- R8: `doneStb` is high for exactly one clock. It rises on the same edge at which `busy` falls, once per operation.
- R9: A `startReq` that arrives while `busy` is 1 has no effect on the running operation and starts no new one.
- R10: Each operation produces exactly one low interval on `driveLow`, and `driveLow` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-clock enable, once per microsecond |
| startReq | input | 1 | Start strobe, taken only while idle |
| opCode | input | 2 | Operation select (see R2) |
| lineIn | input | 1 | Resolved bus level (1 = high) |
| driveLow | output | 1 | Pull-down enable for the open-drain driver |
| busy | output | 1 | An operation is in progress |
| doneStb | output | 1 | One-clock completion strobe |
| presenceFlag | output | 1 | A device answered the last reset |
| readBit | output | 1 | Bit sampled by the last read |

## Verification
The bench keeps every timing parameter at its default: 500/500 µs reset phases, a 70 µs presence offset, 6 µs and 64 µs low times, a 13 µs read sample point and a 70 µs slot. It drives the tick once every three clocks. With these values a full reset fits in a few thousand cycles. A modelled device can also hold the line low across exact tick windows. That makes it possible to place a pull-down edge exactly on, or one tick beside, the presence and read sample points, and so to pin both sample instants to a single tick.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_RESET  = 2'b00,
    OP_WRITE1 = 2'b01,
    OP_WRITE0 = 2'b10,
    OP_READ   = 2'b11
  } owmOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   clrCnt;
    logic   incCnt;
    logic   capPres;
    logic   capBit;
    owmOp_e op;
  } ctrlStb_t;

  // threshold hits from datapath to control, each qualified by the tick
  typedef struct packed {
    logic hitLow;
    logic hitSample;
    logic hitEnd;
  } dpFlag_t;

endpackage

// File: rtl/owm_slot_dp.sv
module owm_slot_dp
  import owm_pkg::*;
#(
  parameter int RST_LOW_US     = 500,
  parameter int RST_HIGH_US    = 500,
  parameter int PRES_SAMPLE_US = 70,
  parameter int BIT1_LOW_US    = 6,
  parameter int BIT0_LOW_US    = 64,
  parameter int READ_SAMPLE_US = 13,
  parameter int SLOT_US        = 70
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickUs,
  input  logic     lineIn,
  input  ctrlStb_t stb,
  output dpFlag_t  flags,
  output logic     presenceFlag,
  output logic     readBit
);

  localparam int RST_TOTAL  = RST_LOW_US + RST_HIGH_US;
  localparam int RST_SAMPLE = RST_LOW_US + PRES_SAMPLE_US;
  localparam int MAX_CNT    = (RST_TOTAL > SLOT_US) ? RST_TOTAL : SLOT_US;
  localparam int CW         = $clog2(MAX_CNT + 1);

  logic [CW-1:0] elapsedUs;
  logic [CW-1:0] nextUs;
  logic [CW-1:0] lowLen;
  logic [CW-1:0] sampleAt;
  logic [CW-1:0] endAt;
  logic          stepNow;

  assign nextUs  = elapsedUs + CW'(1);
  assign stepNow = tickUs && stb.incCnt;

  always_comb begin
    unique case (stb.op)
      OP_RESET: begin
        lowLen   = CW'(RST_LOW_US);
        sampleAt = CW'(RST_SAMPLE);
        endAt    = CW'(RST_TOTAL);
      end
      OP_WRITE1: begin
        lowLen   = CW'(BIT1_LOW_US);
        sampleAt = CW'(READ_SAMPLE_US);
        endAt    = CW'(SLOT_US);
      end
      OP_WRITE0: begin
        lowLen   = CW'(BIT0_LOW_US);
        sampleAt = CW'(READ_SAMPLE_US);
        endAt    = CW'(SLOT_US);
      end
      default: begin
        lowLen   = CW'(BIT1_LOW_US);
        sampleAt = CW'(READ_SAMPLE_US);
        endAt    = CW'(SLOT_US);
      end
    endcase
  end

  assign flags.hitLow    = stepNow && (nextUs == lowLen);
  assign flags.hitSample = stepNow && (nextUs == sampleAt);
  assign flags.hitEnd    = stepNow && (nextUs == endAt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      elapsedUs <= '0;
    end else if (stb.clrCnt) begin
      elapsedUs <= '0;
    end else if (stepNow) begin
      elapsedUs <= nextUs;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presenceFlag <= 1'b0;
      readBit      <= 1'b0;
    end else begin
      if (stb.capPres) presenceFlag <= !lineIn;
      if (stb.capBit)  readBit      <= lineIn;
    end
  end

endmodule

// File: rtl/owm_slot_ctrl.sv
module owm_slot_ctrl
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic [1:0] opCode,
  input  dpFlag_t    flags,
  output ctrlStb_t   stb,
  output logic       driveLow,
  output logic       busy,
  output logic       doneStb
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_PULL  = 2'b01,
    ST_FLOAT = 2'b10
  } slotState_e;

  slotState_e state;
  owmOp_e     curOp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curOp   <= OP_RESET;
      doneStb <= 1'b0;
    end else begin
      doneStb <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            curOp <= owmOp_e'(opCode);
            state <= ST_PULL;
          end
        end
        ST_PULL: begin
          if (flags.hitLow) state <= ST_FLOAT;
        end
        ST_FLOAT: begin
          if (flags.hitEnd) begin
            state   <= ST_IDLE;
            doneStb <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign driveLow    = (state == ST_PULL);
  assign busy        = (state != ST_IDLE);

  assign stb.clrCnt  = (state == ST_IDLE);
  assign stb.incCnt  = (state != ST_IDLE);
  assign stb.capPres = (state == ST_FLOAT) && (curOp == OP_RESET) && flags.hitSample;
  assign stb.capBit  = (state == ST_FLOAT) && (curOp == OP_READ) && flags.hitSample;
  assign stb.op      = curOp;

endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
  import owm_pkg::*;
#(
  parameter int RST_LOW_US     = 500,
  parameter int RST_HIGH_US    = 500,
  parameter int PRES_SAMPLE_US = 70,
  parameter int BIT1_LOW_US    = 6,
  parameter int BIT0_LOW_US    = 64,
  parameter int READ_SAMPLE_US = 13,
  parameter int SLOT_US        = 70
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickUs,
  input  logic       startReq,
  input  logic [1:0] opCode,
  input  logic       lineIn,
  output logic       driveLow,
  output logic       busy,
  output logic       doneStb,
  output logic       presenceFlag,
  output logic       readBit
);

  ctrlStb_t stb;
  dpFlag_t  flags;

  owm_slot_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .opCode   (opCode),
    .flags    (flags),
    .stb      (stb),
    .driveLow (driveLow),
    .busy     (busy),
    .doneStb  (doneStb)
  );

  owm_slot_dp #(
    .RST_LOW_US     (RST_LOW_US),
    .RST_HIGH_US    (RST_HIGH_US),
    .PRES_SAMPLE_US (PRES_SAMPLE_US),
    .BIT1_LOW_US    (BIT1_LOW_US),
    .BIT0_LOW_US    (BIT0_LOW_US),
    .READ_SAMPLE_US (READ_SAMPLE_US),
    .SLOT_US        (SLOT_US)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .tickUs       (tickUs),
    .lineIn       (lineIn),
    .stb          (stb),
    .flags        (flags),
    .presenceFlag (presenceFlag),
    .readBit      (readBit)
  );

endmodule

// File: rtl/owm_slot_engine_chk.sv
module owm_slot_engine_chk #(
  parameter int RST_LOW_US  = 500,
  parameter int BIT1_LOW_US = 6,
  parameter int BIT0_LOW_US = 64
) (
  input logic clk,
  input logic rstN,
  input logic tickUs,
  input logic startReq,
  input logic driveLow,
  input logic busy,
  input logic doneStb,
  input logic presenceFlag,
  input logic readBit
);

  // tick edges seen while the line is pulled; holds the full count the cycle it falls
  logic [15:0] lowTicks;
  always_ff @(posedge clk) begin
    if (!rstN)         lowTicks <= '0;
    else if (driveLow) lowTicks <= lowTicks + (tickUs ? 16'd1 : 16'd0);
    else               lowTicks <= '0;
  end

  p_no_idle_pull_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !driveLow);

  p_start_pulls_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> (busy && driveLow));

  p_pull_needs_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(driveLow) |-> $past(startReq && !busy));

  p_done_one_clock_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (!busy && $past(busy)));

  p_low_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(driveLow) |-> (int'(lowTicks) == BIT1_LOW_US || int'(lowTicks) == BIT0_LOW_US
                         || int'(lowTicks) == RST_LOW_US));

  p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(presenceFlag) && $stable(readBit)));

endmodule

bind owm_slot_engine owm_slot_engine_chk #(
  .RST_LOW_US  (RST_LOW_US),
  .BIT1_LOW_US (BIT1_LOW_US),
  .BIT0_LOW_US (BIT0_LOW_US)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .tickUs       (tickUs),
  .startReq     (startReq),
  .driveLow     (driveLow),
  .busy         (busy),
  .doneStb      (doneStb),
  .presenceFlag (presenceFlag),
  .readBit      (readBit)
);

// File: tb/owm_slot_engine_tb_top.sv
module owm_slot_engine_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickUs = 1'b0;
  logic       startReq = 1'b0;
  logic [1:0] opCode = 2'b00;
  logic       lineIn;
  logic       driveLow, busy, doneStb, presenceFlag, readBit;
  logic       slaveLow = 1'b0;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // monitor state, reset by the tasks at the start of every operation
  int lowTicks = 0;
  int busyTicks = 0;
  int lowRises = 0;
  int doneCycles = 0;
  int idlePulls = 0;
  int winLo = 0;
  int winHi = 0;
  logic prevLow = 1'b0;
  int divCnt = 0;

  always #5 clk = ~clk;

  assign lineIn = !(driveLow || slaveLow);

  owm_slot_engine dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .tickUs       (tickUs),
    .startReq     (startReq),
    .opCode       (opCode),
    .lineIn       (lineIn),
    .driveLow     (driveLow),
    .busy         (busy),
    .doneStb      (doneStb),
    .presenceFlag (presenceFlag),
    .readBit      (readBit)
  );

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick generator, tick counters and device model, all away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (tickUs && driveLow) lowTicks++;
      if (tickUs && busy) busyTicks++;
      if (driveLow && !prevLow) lowRises++;
      prevLow = driveLow;
      if (doneStb) doneCycles++;
      if (!busy && driveLow) idlePulls++;
      slaveLow = busy && (busyTicks >= winLo) && (busyTicks < winHi);
      divCnt = (divCnt == 2) ? 0 : divCnt + 1;
      tickUs = (divCnt == 0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        summary();
      end
    end
  end

  // start one operation; optionally strobe another start while it runs
  task automatic run_op(input logic [1:0] op, input int lo, input int hi, input bit intrude,
                        input string req);
    @(negedge clk);
    lowTicks = 0; busyTicks = 0; lowRises = 0; doneCycles = 0;
    winLo = lo; winHi = hi;
    startReq = 1'b1;
    opCode = op;
    @(negedge clk);
    startReq = 1'b0;
    chk(busy && driveLow, {req, " R2 start"}, int'({busy, driveLow}), 3);
    if (intrude) begin
      repeat (40) @(negedge clk);
      startReq = 1'b1;
      opCode = 2'b00;
      @(negedge clk);
      startReq = 1'b0;
      opCode = op;
    end
    while (doneCycles == 0) @(negedge clk);
    chk(!busy, {req, " R8 busy falls with done"}, int'(busy), 0);
    repeat (4) @(negedge clk);
    chk(doneCycles == 1, {req, " R8 done width"}, doneCycles, 1);
    chk(lowRises == 1, {req, " R10 one low interval"}, lowRises, 1);
  endtask

  task automatic t_reset_state();
    chk(!driveLow && !busy && !doneStb && !presenceFlag && !readBit, "R1 reset state",
        int'({driveLow, busy, doneStb, presenceFlag, readBit}), 0);
  endtask

  task automatic t_bus_reset(input int lo, input int hi, input bit expPres, input string tag);
    run_op(2'b00, lo, hi, 1'b0, tag);
    chk(lowTicks == 500, {tag, " R3 reset low"}, lowTicks, 500);
    chk(busyTicks == 1000, {tag, " R3 reset total"}, busyTicks, 1000);
    chk(presenceFlag == expPres, {tag, " R4 presence"}, int'(presenceFlag), int'(expPres));
  endtask

  task automatic t_write(input logic [1:0] op, input int expLow, input string tag);
    run_op(op, 0, 0, 1'b0, tag);
    chk(lowTicks == expLow, {tag, " low time"}, lowTicks, expLow);
    chk(busyTicks == 70, {tag, " slot length"}, busyTicks, 70);
  endtask

  task automatic t_read(input int hi, input bit expBit, input string tag);
    run_op(2'b11, 0, hi, 1'b0, tag);
    chk(lowTicks == 6, {tag, " R7 read low"}, lowTicks, 6);
    chk(busyTicks == 70, {tag, " R7 read slot"}, busyTicks, 70);
    chk(readBit == expBit, {tag, " R7 sampled bit"}, int'(readBit), int'(expBit));
  endtask

  task automatic t_busy_ignore();
    run_op(2'b10, 0, 0, 1'b1, "R9 ignore");
    chk(lowTicks == 64, "R9 low unchanged", lowTicks, 64);
    chk(busyTicks == 70, "R9 slot unchanged", busyTicks, 70);
    repeat (30) @(negedge clk);
    chk(!busy && !driveLow, "R9 no second op", int'({busy, driveLow}), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_state();
    // device answers across the sample tick: present
    t_bus_reset(560, 600, 1'b1, "R4 answer");
    // device releases exactly at the sample tick: absent
    t_bus_reset(540, 570, 1'b0, "R4 late");
    // device starts pulling exactly at the sample tick: present
    t_bus_reset(570, 600, 1'b1, "R4 edge");
    t_write(2'b01, 6, "R5 write-one");
    t_write(2'b10, 64, "R6 write-zero");
    // device releases at the sample tick: bit 1
    t_read(13, 1'b1, "R7 release at 13");
    // device holds one tick past the sample: bit 0
    t_read(14, 1'b0, "R7 hold to 14");
    chk(presenceFlag == 1'b1, "R4 presence held over reads", int'(presenceFlag), 1);
    t_read(0, 1'b1, "R7 idle line");
    t_bus_reset(0, 0, 1'b0, "R4 empty bus");
    t_busy_ignore();
    chk(idlePulls == 0, "R10 no pull while idle", idlePulls, 0);
    summary();
  end

endmodule